// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Chopper

This block is the digital side of the current regulation loop for one H-bridge winding. Each PWM cycle starts by switching the bridge on. A blanking window follows, and during it the current-trip comparator is disregarded so that switching spikes cannot end the on-phase early. After blanking, the bridge stays on until the comparator reports that the winding current has reached its trip level. The bridge is then held off for a constant number of clock cycles before the next cycle begins.

The off-time is spent in one of two decay styles. In slow decay the whole interval recirculates current slowly. In mixed decay the interval opens with a fast-decay portion, whose length is a fixed fraction of the off-time, and continues in slow decay for the rest. Mixed decay is used when a request input asks for it or when the automatic-mixed option is set. The choice is captured at the moment the off-time begins. The comparator input passes through a configurable synchronizer. An enable input and a fault input return the bridge to its fully-off state.

Top module: `pwm_chopper`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, bridge_mode is 0 (all bridge switches off). The full bridge_mode encoding is: 0 off, 1 driven, 2 fast decay, 3 slow decay.
- R2: At any clock edge where enable is low or fault is high, the controller enters its off state. bridge_mode reads 0 from the following cycle for as long as that condition holds.
- R3: A PWM cycle entered from the off state shows bridge_mode 1 from the cycle after the first edge with enable high and fault low. Its first BLANK_CYCLES cycles form a blanking window in which trip has no effect. A trip pulse that is seen only inside the window leaves bridge_mode at 1.
- R4: trip is delayed by SYNC_STAGES clock edges. A trip level sampled at edge k acts at edge k+SYNC_STAGES. If blanking has ended by that edge, the off-time begins at that edge.
- R5: When slow decay is selected, the off-time shows bridge_mode 3 for exactly OFF_CYCLES cycles.
- R6: When mixed decay is selected, the off-time shows bridge_mode 2 for FAST_CYCLES = floor(OFF_CYCLES*FAST_NUM/FAST_DEN) cycles. It then shows bridge_mode 3 for OFF_CYCLES-FAST_CYCLES cycles, for OFF_CYCLES cycles in total.
- R7: Mixed decay is selected when auto_mixed or mixed_req is high at the edge where the off-time begins. Changes to either input during an off-time have no effect on that off-time.
- R8: After each off-time a new cycle starts with a fresh blanking window (bridge_mode 1). With no trip, bridge_mode stays 1 indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High allows regulation; low forces the bridge off |
| fault | input | 1 | High forces the bridge off |
| trip | input | 1 | Current-trip comparator output, high at or above trip level |
| mixed_req | input | 1 | Requests mixed decay for the next off-time |
| auto_mixed | input | 1 | Forces mixed decay for every off-time |
| bridge_mode | output | 2 | Bridge drive state: 0 off, 1 driven, 2 fast decay, 3 slow decay |

## Verification
Two situations are the hardest to reach from the ports. The first is a trip that reaches the controller exactly on the last blanking cycle or the first cycle after it, once the synchronizer delay has been added. The bench covers it by sweeping the start of a short trip pulse one cycle at a time across the whole blanking window, for every combination of the two mode inputs. The second is a decay-mode input that flips in the middle of an off-time. The bench reaches it by toggling mixed_req inside fast decay and again inside slow decay. A long pseudo-random run then mixes trips, mode changes, disables and faults at arbitrary phases.

// File: rtl/chop_pkg.sv
package chop_pkg;

   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_BLANK = 3'd1,
      ST_ON    = 3'd2,
      ST_FAST  = 3'd3,
      ST_SLOW  = 3'd4
   } chop_state_e;

   typedef enum logic [1:0] {
      BR_OFF   = 2'd0,
      BR_DRIVE = 2'd1,
      BR_FAST  = 2'd2,
      BR_SLOW  = 2'd3
   } bridge_e;

   function automatic int fast_len(input int off_cyc, input int num, input int den);
      return (off_cyc * num) / den;
   endfunction

endpackage

// File: rtl/chop_trip_sync.sv
module chop_trip_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '0;
            end else begin
               for (int i = STAGES - 1; i > 0; i--) begin
                  sr[i] <= sr[i-1];
               end
               sr[0] <= din;
            end
         end
         assign dout = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
   import chop_pkg::*;
#(
   parameter int OFF_CYCLES   = 1000,
   parameter int BLANK_CYCLES = 50,
   parameter int FAST_CYCLES  = 312,
   parameter int CNT_W        = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_ok,
   input  logic             trip_s,
   input  logic             mixed_sel,
   input  logic             tmr_expired,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output chop_state_e      state
);
   localparam logic [CNT_W-1:0] BLANK_LD = CNT_W'(BLANK_CYCLES - 1);
   localparam logic [CNT_W-1:0] OFF_LD   = CNT_W'(OFF_CYCLES - 1);
   localparam logic [CNT_W-1:0] FAST_LD  = CNT_W'(FAST_CYCLES - 1);
   localparam logic [CNT_W-1:0] TAIL_LD  = CNT_W'(OFF_CYCLES - FAST_CYCLES - 1);

   chop_state_e nxt;

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (!run_ok) begin
         nxt = ST_OFF;
      end else begin
         unique case (state)
            ST_OFF: begin
               nxt      = ST_BLANK;
               tmr_load = 1'b1;
               tmr_val  = BLANK_LD;
            end
            ST_BLANK: begin
               if (tmr_expired) nxt = ST_ON;
            end
            ST_ON: begin
               if (trip_s) begin
                  tmr_load = 1'b1;
                  if (mixed_sel) begin
                     nxt     = ST_FAST;
                     tmr_val = FAST_LD;
                  end else begin
                     nxt     = ST_SLOW;
                     tmr_val = OFF_LD;
                  end
               end
            end
            ST_FAST: begin
               if (tmr_expired) begin
                  nxt      = ST_SLOW;
                  tmr_load = 1'b1;
                  tmr_val  = TAIL_LD;
               end
            end
            ST_SLOW: begin
               if (tmr_expired) begin
                  nxt      = ST_BLANK;
                  tmr_load = 1'b1;
                  tmr_val  = BLANK_LD;
               end
            end
            default: nxt = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_OFF;
      else        state <= nxt;
   end
endmodule

// File: rtl/chop_drive_dec.sv
module chop_drive_dec
   import chop_pkg::*;
(
   input  chop_state_e state,
   output bridge_e     drive
);
   always_comb begin
      unique case (state)
         ST_BLANK, ST_ON: drive = BR_DRIVE;
         ST_FAST:         drive = BR_FAST;
         ST_SLOW:         drive = BR_SLOW;
         default:         drive = BR_OFF;
      endcase
   end
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
   import chop_pkg::*;
#(
   parameter int OFF_CYCLES   = 1000,
   parameter int BLANK_CYCLES = 50,
   parameter int FAST_NUM     = 5,
   parameter int FAST_DEN     = 16,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       fault,
   input  logic       trip,
   input  logic       mixed_req,
   input  logic       auto_mixed,
   output logic [1:0] bridge_mode
);
   localparam int FAST_CYCLES = fast_len(OFF_CYCLES, FAST_NUM, FAST_DEN);
   localparam int MAX_LOAD    = (OFF_CYCLES > BLANK_CYCLES) ? OFF_CYCLES : BLANK_CYCLES;
   localparam int CNT_W       = $clog2(MAX_LOAD + 1);

   generate
      if (BLANK_CYCLES < 1) begin : g_chk_blank
         $error("BLANK_CYCLES must be at least 1");
      end
      if (OFF_CYCLES < 2) begin : g_chk_off
         $error("OFF_CYCLES must be at least 2");
      end
      if (FAST_DEN < 1 || FAST_NUM < 1 || FAST_NUM >= FAST_DEN) begin : g_chk_frac
         $error("FAST_NUM/FAST_DEN must be a fraction strictly between 0 and 1");
      end
      if (FAST_CYCLES < 1 || FAST_CYCLES >= OFF_CYCLES) begin : g_chk_fast
         $error("fast-decay portion must be at least one cycle and shorter than the off-time");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_chk_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic             trip_s;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   chop_state_e      state;
   bridge_e          drive;

   chop_trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (trip),
      .dout (trip_s)
   );

   chop_timer #(.W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .expired (tmr_expired)
   );

   chop_fsm #(
      .OFF_CYCLES  (OFF_CYCLES),
      .BLANK_CYCLES(BLANK_CYCLES),
      .FAST_CYCLES (FAST_CYCLES),
      .CNT_W       (CNT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_ok     (enable & ~fault),
      .trip_s     (trip_s),
      .mixed_sel  (auto_mixed | mixed_req),
      .tmr_expired(tmr_expired),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .state      (state)
   );

   chop_drive_dec u_dec (
      .state(state),
      .drive(drive)
   );

   assign bridge_mode = drive;
endmodule

// File: rtl/chop_checker.sv
module chop_checker #(
   parameter int OFF_CYCLES   = 1000,
   parameter int BLANK_CYCLES = 50,
   parameter int FAST_CYCLES  = 312
) (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic       fault,
   input logic       mixed_req,
   input logic       auto_mixed,
   input logic [1:0] bridge_mode
);
   logic [31:0] on_run;
   logic [31:0] off_run;
   logic [31:0] fast_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_run   <= '0;
         off_run  <= '0;
         fast_run <= '0;
      end else begin
         on_run   <= (bridge_mode == 2'd1) ? ((on_run == '1) ? on_run : on_run + 1) : '0;
         off_run  <= (bridge_mode[1]) ? off_run + 1 : '0;
         fast_run <= (bridge_mode == 2'd2) ? fast_run + 1 : '0;
      end
   end

   assert_off_when_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable || fault) |=> (bridge_mode == 2'd0));

   assert_restart_in_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bridge_mode) == 2'd0 && bridge_mode != 2'd0) |-> (bridge_mode == 2'd1));

   assert_blank_respected_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bridge_mode) == 2'd1 && bridge_mode[1]) |-> (on_run >= 32'(BLANK_CYCLES + 1)));

   assert_offtime_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bridge_mode) == 2'd3 && bridge_mode == 2'd1) |-> (off_run == 32'(OFF_CYCLES)));

   assert_offtime_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      off_run <= 32'(OFF_CYCLES));

   assert_fast_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bridge_mode) == 2'd2 && bridge_mode == 2'd3) |-> (fast_run == 32'(FAST_CYCLES)));

   assert_fast_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bridge_mode == 2'd2) |=> (bridge_mode != 2'd1));

   assert_fast_needs_mixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bridge_mode) == 2'd1 && bridge_mode == 2'd2) |-> $past(auto_mixed || mixed_req));

   assert_slow_needs_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bridge_mode) == 2'd1 && bridge_mode == 2'd3) |-> !$past(auto_mixed || mixed_req));

   assert_cycle_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bridge_mode) == 2'd3 && bridge_mode != 2'd3) |-> (bridge_mode != 2'd2));
endmodule

bind pwm_chopper chop_checker #(
   .OFF_CYCLES  (OFF_CYCLES),
   .BLANK_CYCLES(BLANK_CYCLES),
   .FAST_CYCLES (FAST_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .fault      (fault),
   .mixed_req  (mixed_req),
   .auto_mixed (auto_mixed),
   .bridge_mode(bridge_mode)
);

// File: tb/pwm_chopper_test.sv
`timescale 1ns/1ps
module pwm_chopper_test;
   localparam int OFFC  = 16;
   localparam int BLNK  = 4;
   localparam int FNUM  = 5;
   localparam int FDEN  = 16;
   localparam int SYNC  = 2;
   localparam int FASTC = (OFFC * FNUM) / FDEN;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic fault = 1'b0;
   logic trip = 1'b0;
   logic mixed_req = 1'b0;
   logic auto_mixed = 1'b0;
   logic [1:0] bridge_mode;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // reference model: 0 off, 1 blank, 2 on, 3 fast, 4 slow
   int m_st = 0;
   int m_cnt = 0;
   bit tp0 = 1'b0;
   bit tp1 = 1'b0;

   pwm_chopper #(
      .OFF_CYCLES  (OFFC),
      .BLANK_CYCLES(BLNK),
      .FAST_NUM    (FNUM),
      .FAST_DEN    (FDEN),
      .SYNC_STAGES (SYNC)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .fault      (fault),
      .trip       (trip),
      .mixed_req  (mixed_req),
      .auto_mixed (auto_mixed),
      .bridge_mode(bridge_mode)
   );

   always #5 clk = ~clk;

   task automatic model_edge();
      bit seen;
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; tp0 = 0; tp1 = 0;
         return;
      end
      seen = tp1;
      tp1 = tp0;
      tp0 = trip;
      if (!enable || fault) begin
         m_st = 0;
      end else begin
         case (m_st)
            0: begin m_st = 1; m_cnt = BLNK - 1; end
            1: if (m_cnt == 0) m_st = 2; else m_cnt--;
            2: if (seen) begin
                  if (auto_mixed || mixed_req) begin m_st = 3; m_cnt = FASTC - 1; end
                  else begin m_st = 4; m_cnt = OFFC - 1; end
               end
            3: if (m_cnt == 0) begin m_st = 4; m_cnt = OFFC - FASTC - 1; end else m_cnt--;
            default: if (m_cnt == 0) begin m_st = 1; m_cnt = BLNK - 1; end else m_cnt--;
         endcase
      end
   endtask

   function automatic int exp_code();
      case (m_st)
         1, 2: return 1;
         3: return 2;
         4: return 3;
         default: return 0;
      endcase
   endfunction

   task automatic step(input string tag);
      string t;
      int e;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      e = exp_code();
      if (tag != "") t = tag;
      else if (e == 0) t = "R2";
      else if (e == 1) t = "R8";
      else if (e == 2) t = "R6";
      else t = "R5";
      vectors++;
      if (int'(bridge_mode) != e) begin
         miscompares++;
         $display("FAIL %s: bridge_mode=%0d expected %0d (vector %0d)", t, bridge_mode, e, vectors);
      end
   endtask

   task automatic steps(input int n, input string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog (all requirements): actual hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      // R1: reset holds the bridge off even with enable high
      @(negedge clk);
      enable = 1'b1;
      steps(3, "R1");
      rst_n = 1'b1;
      enable = 1'b0;
      steps(1, "R1");
      // R2: disabled stays off
      steps(3, "R2");
      // R3 / R8: enable, no trip, drive persists
      enable = 1'b1;
      steps(2, "R3");
      steps(40, "R8");

      // R3/R4/R5/R6: trip pulse swept across the blanking window, all mode combinations
      for (int mode = 0; mode < 4; mode++) begin
         for (int d = 0; d < BLNK + 4; d++) begin
            enable = 1'b0;
            steps(2, "R2");
            auto_mixed = mode[1];
            mixed_req  = mode[0];
            enable = 1'b1;
            steps(d, "R3");
            trip = 1'b1;
            steps(1, "R4");
            trip = 1'b0;
            steps(3, "R4");
            steps(OFFC + BLNK + 4, "");
         end
      end
      auto_mixed = 1'b0;
      mixed_req  = 1'b0;

      // R2: fault during drive and during off-time
      trip = 1'b1;
      steps(BLNK + 6, "");
      fault = 1'b1;
      steps(3, "R2");
      fault = 1'b0;
      trip = 1'b0;
      steps(BLNK + 3, "R3");

      // R7: mode request flips inside fast decay
      mixed_req = 1'b1;
      trip = 1'b1;
      steps(SYNC + 1, "R7");
      trip = 1'b0;
      steps(1, "R7");
      mixed_req = 1'b0;
      steps(OFFC + 2, "R7");
      // R7: mode request flips inside slow decay
      steps(BLNK + 2, "R8");
      trip = 1'b1;
      steps(SYNC + 1, "R7");
      trip = 1'b0;
      steps(1, "R7");
      mixed_req = 1'b1;
      auto_mixed = 1'b1;
      steps(OFFC + 2, "R7");
      mixed_req = 1'b0;
      auto_mixed = 1'b0;

      // pseudo-random mix of every input
      lfsr = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         trip       = (lfsr[3:0] < 4'd5);
         if (lfsr[9:6] == 4'd0) mixed_req = ~mixed_req;
         if (lfsr[13:10] == 4'd1) auto_mixed = ~auto_mixed;
         enable     = !(lfsr[15:11] == 5'd3);
         fault      = (lfsr[15:10] == 6'd9);
         step("");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule